// File: doc/BRIEF.md
# Output Port Register with A20 Gate and Reset Pulse

This block holds the 8-bit output port of a keyboard-style system controller. The port drives two system signals. Bit 1 is the A20 address gate and bit 0 is the "not in reset" flag. Software changes the port in one of two ways. It can write a whole new byte through the direct write path. It can also issue single-byte commands that raise or lower the A20 gate, or that request a reset pulse.

Any command whose upper four bits are all ones belongs to the pulse family. Its bit 0 decides the outcome: a zero requests a system reset and a one makes the command a no-op. A direct write whose bit 0 is zero also requests a reset. A request drives a reset output for a fixed, parameterised number of clocks. A request that arrives while that output is already high starts the count again.

Bits 4 and 5 of the read-back value are not stored. They show the keyboard and auxiliary output-buffer-full flags, which come from the buffer arbiter.

Top module: `opc_outport`

## Requirements
- R1: After reset, `port_value` is 0xCF (with both buffer-full inputs low), `a20_out` is 1 and `sys_reset_req` is 0.
- R2: A direct write (`port_wr_valid`) stores bits 0-3 and 6-7 of `port_wr_data`, and they appear in `port_value` in the cycle after the write.
- R3: After a direct write, `a20_out` equals bit 1 of the written byte from the next cycle on. At all times `a20_out` equals bit 1 of `port_value`.
- R4: A direct write with bit 0 = 0 makes `sys_reset_req` high for exactly PULSE_LEN cycles, starting the cycle after the write. A direct write with bit 0 = 1 requests nothing.
- R5: Command 0xDF sets port bit 1, and command 0xDD clears it. `a20_out` follows in the next cycle, and all other port bits keep their value.
- R6: A command with bits 7:4 = 0xF and bit 0 = 0 (for example 0xFE, 0xF0, 0xFA) starts a reset pulse of PULSE_LEN cycles and leaves the port value unchanged.
- R7: A command with bits 7:4 = 0xF and bit 0 = 1 (for example 0xFF, 0xF1, 0xF5) has no effect: the port value is unchanged and no reset pulse starts.
- R8: All other command bytes (for example 0x20, 0xD1, 0xAA) leave the port value, `a20_out` and `sys_reset_req` unchanged.
- R9: Bit 4 of `port_value` equals `kbd_full` and bit 5 equals `aux_full` in the same cycle. Bits 4 and 5 of a written byte are discarded.
- R10: A reset request that arrives while `sys_reset_req` is high restarts the count. The output then stays high for PULSE_LEN cycles after the latest request.
- R11: When a direct write and a command arrive in the same cycle, only the write takes effect and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| port_wr_valid | input | 1 | Direct output-port write strobe |
| port_wr_data | input | 8 | Byte written to the output port |
| kbd_full | input | 1 | Keyboard output buffer full, shown on bit 4 |
| aux_full | input | 1 | Auxiliary output buffer full, shown on bit 5 |
| port_value | output | 8 | Read-back value of the output port |
| a20_out | output | 1 | Registered A20 gate line |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
Every stored result is due one clock edge after its stimulus: the port bits, `a20_out`, and the rising edge of `sys_reset_req`. The reset pulse then stays high for PULSE_LEN edges after the latest request. The mirror bits 4 and 5 are combinational and are due in the same cycle as the flags. The driver applies each stimulus on a falling edge and queues the value expected after the following rising edge. The monitor takes that entry 2 ns after the rising edge, so each comparison falls exactly one register stage after its stimulus, and pulse length and restart are checked cycle by cycle.

// File: rtl/opc_pkg.sv
package opc_pkg;
    localparam int PORT_W  = 8;
    localparam int RST_BIT = 0;
    localparam int A20_BIT = 1;
    localparam int KBD_BIT = 4;
    localparam int AUX_BIT = 5;

    localparam logic [PORT_W-1:0] PORT_RESET_VAL = 8'hCF;
    localparam logic [PORT_W-1:0] MIRROR_MASK =
        PORT_W'((1 << KBD_BIT) | (1 << AUX_BIT));
    localparam logic [PORT_W-1:0] STORE_MASK = ~MIRROR_MASK;

    localparam logic [7:0] CMD_A20_ON   = 8'hDF;
    localparam logic [7:0] CMD_A20_OFF  = 8'hDD;
    localparam logic [3:0] CMD_PULSE_HI = 4'hF;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_A20_ON,
        ACT_A20_OFF,
        ACT_PULSE
    } opc_act_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
    } opc_state_t;
endpackage

// File: rtl/opc_cmd_decode.sv
module opc_cmd_decode
    import opc_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output opc_act_e   act
);
    always_comb begin
        act = ACT_NONE;
        if (cmd_byte[7:4] == CMD_PULSE_HI) begin
            // pulse family: bit 0 low means reset, high means no-op
            act = cmd_byte[0] ? ACT_NONE : ACT_PULSE;
        end else if (cmd_byte == CMD_A20_ON) begin
            act = ACT_A20_ON;
        end else if (cmd_byte == CMD_A20_OFF) begin
            act = ACT_A20_OFF;
        end
    end
endmodule

// File: rtl/opc_pulse_gen.sv
module opc_pulse_gen #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic active
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trigger) begin
            st_d.cnt = CNT_W'(PULSE_LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.cnt != '0);

    // R10: a request reloads the full length, even mid-pulse
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (st_q.cnt == CNT_W'(PULSE_LEN)) && active);

    // R4: the pulse ends after its last counted cycle
    a_r4_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(1)) && !trigger |=> !active);
endmodule

// File: rtl/opc_readback.sv
module opc_readback
    import opc_pkg::*;
(
    input  logic [PORT_W-1:0] stored,
    input  logic              kbd_full,
    input  logic              aux_full,
    output logic [PORT_W-1:0] value
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        if (i == KBD_BIT) begin : g_kbd
            assign value[i] = stored[i] | kbd_full;
        end else if (i == AUX_BIT) begin : g_aux
            assign value[i] = stored[i] | aux_full;
        end else begin : g_plain
            assign value[i] = stored[i];
        end
    end

    // R9: mirror bits follow the flags only (storage never holds them)
    always_comb begin
        a_r9_mirror: assert ((value[KBD_BIT] == kbd_full) && (value[AUX_BIT] == aux_full));
    end
endmodule

// File: rtl/opc_outport.sv
module opc_outport
    import opc_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              port_wr_valid,
    input  logic [PORT_W-1:0] port_wr_data,
    input  logic              kbd_full,
    input  logic              aux_full,
    output logic [PORT_W-1:0] port_value,
    output logic              a20_out,
    output logic              sys_reset_req
);
    opc_state_t st_d, st_q;
    opc_act_e   act;
    logic       trigger;

    opc_cmd_decode u_decode (
        .cmd_byte (cmd_byte),
        .act      (act)
    );

    always_comb begin
        st_d    = st_q;
        trigger = 1'b0;
        if (port_wr_valid) begin
            // direct write has priority; a same-cycle command is dropped
            st_d.port = port_wr_data & STORE_MASK;
            trigger   = ~port_wr_data[RST_BIT];
        end else if (cmd_valid) begin
            unique case (act)
                ACT_A20_ON:  st_d.port[A20_BIT] = 1'b1;
                ACT_A20_OFF: st_d.port[A20_BIT] = 1'b0;
                ACT_PULSE:   trigger = 1'b1;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.port <= PORT_RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    opc_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .active  (sys_reset_req)
    );

    opc_readback u_readback (
        .stored   (st_q.port),
        .kbd_full (kbd_full),
        .aux_full (aux_full),
        .value    (port_value)
    );

    assign a20_out = st_q.port[A20_BIT];

    // R3: gate line follows bit 1 of the written byte
    a_r3_a20_write: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_valid |=> a20_out == $past(port_wr_data[A20_BIT]));

    // R4: written bit 0 low requests reset
    a_r4_write_reset: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_valid && !port_wr_data[RST_BIT] |=> sys_reset_req);

    // R5: enable command raises the gate
    a_r5_a20_on: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !port_wr_valid && (cmd_byte == CMD_A20_ON) |=> a20_out);

    // R6: pulse command with bit 0 low resets and keeps the port
    a_r6_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !port_wr_valid && (cmd_byte[7:4] == CMD_PULSE_HI) && !cmd_byte[0]
        |=> sys_reset_req && $stable(st_q.port));

    // R7: pulse command with bit 0 high does nothing
    a_r7_cmd_noop: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !port_wr_valid && (cmd_byte[7:4] == CMD_PULSE_HI) && cmd_byte[0]
        && !sys_reset_req |=> !sys_reset_req && $stable(st_q.port));

    // R11: a same-cycle command is dropped in favour of the write
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_valid && port_wr_data[RST_BIT] && cmd_valid && !sys_reset_req
        |=> !sys_reset_req);
endmodule

// File: tb/opc_outport_tb.sv
`timescale 1ns/1ps
module opc_outport_tb;
    localparam int LEN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       port_wr_valid = 1'b0;
    logic [7:0] port_wr_data = 8'h00;
    logic       kbd_full = 1'b0;
    logic       aux_full = 1'b0;
    logic [7:0] port_value;
    logic       a20_out;
    logic       sys_reset_req;

    always #4 clk = ~clk;

    opc_outport #(.PULSE_LEN(LEN)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_byte      (cmd_byte),
        .port_wr_valid (port_wr_valid),
        .port_wr_data  (port_wr_data),
        .kbd_full      (kbd_full),
        .aux_full      (aux_full),
        .port_value    (port_value),
        .a20_out       (a20_out),
        .sys_reset_req (sys_reset_req)
    );

    typedef struct {
        logic [7:0] port;
        logic       a20;
        logic       req;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    logic [7:0] mport = 8'hCF;
    int   mcnt = 0;

    // monitor: compare 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (port_value !== e.port || a20_out !== e.a20 || sys_reset_req !== e.req) begin
                bad++;
                $display("FAIL %s: port=%h a20=%b req=%b expected port=%h a20=%b req=%b",
                         e.tag, port_value, a20_out, sys_reset_req, e.port, e.a20, e.req);
            end
        end
    end

    task automatic step(input logic cv, input logic [7:0] cb, input logic wv,
                        input logic [7:0] wd, input logic kf, input logic af,
                        input string tag);
        logic trig;
        exp_t e;
        @(negedge clk);
        cmd_valid = cv; cmd_byte = cb; port_wr_valid = wv; port_wr_data = wd;
        kbd_full = kf; aux_full = af;
        trig = 1'b0;
        if (wv) begin
            mport = wd & 8'hCF;
            trig = !wd[0];
        end else if (cv) begin
            if (cb == 8'hDF) mport[1] = 1'b1;
            else if (cb == 8'hDD) mport[1] = 1'b0;
            else if (cb[7:4] == 4'hF && !cb[0]) trig = 1'b1;
        end
        if (trig) mcnt = LEN;
        else if (mcnt > 0) mcnt--;
        e.port = mport | {2'b00, af, kf, 4'b0000};
        e.a20 = mport[1];
        e.req = (mcnt != 0);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic cmd(input logic [7:0] b, input string tag);
        step(1'b1, b, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] d, input string tag);
        step(1'b0, 8'h00, 1'b1, d, 1'b0, 1'b0, tag);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1, "R1 reset state");
        // R9 mirrors
        step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, "R9 kbd mirror");
        step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R9 aux mirror");
        step(1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, "R9 written bits 4,5 dropped");
        // R2 stored value
        wr(8'h8B, "R2 write 8B");
        wr(8'h43, "R2 write 43");
        // R3 gate from bit 1
        wr(8'h41, "R3 a20 low");
        wr(8'h03, "R3 a20 high");
        // R8 unrelated commands
        cmd(8'h20, "R8 cmd 20");
        cmd(8'hD1, "R8 cmd D1");
        cmd(8'hAA, "R8 cmd AA");
        // R5 gate commands
        cmd(8'hDD, "R5 cmd DD");
        cmd(8'hDF, "R5 cmd DF");
        // R4 reset by write
        wr(8'hCE, "R4 write bit0 low");
        idle(LEN + 1, "R4 pulse length");
        wr(8'hCF, "R4 write bit0 high");
        idle(2, "R4 no pulse");
        // R6 pulse commands
        cmd(8'hFE, "R6 cmd FE");
        idle(LEN + 1, "R6 pulse length");
        cmd(8'hF0, "R6 cmd F0");
        idle(LEN + 1, "R6 pulse F0");
        cmd(8'hFA, "R6 cmd FA");
        idle(LEN + 1, "R6 pulse FA");
        // R7 no-op pulse commands
        cmd(8'hFF, "R7 cmd FF");
        cmd(8'hF1, "R7 cmd F1");
        cmd(8'hF5, "R7 cmd F5");
        idle(1, "R7 still idle");
        // R10 restart
        cmd(8'hFE, "R10 first request");
        idle(2, "R10 mid pulse");
        cmd(8'hFE, "R10 restart");
        idle(LEN + 1, "R10 extended pulse");
        // R11 write wins
        step(1'b1, 8'hDD, 1'b1, 8'hCB, 1'b0, 1'b0, "R11 write beats DD");
        step(1'b1, 8'hFE, 1'b1, 8'h03, 1'b0, 1'b0, "R11 write beats FE");
        idle(2, "R11 no pulse");
        @(negedge clk);
        cmd_valid = 1'b0; port_wr_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule